// File: doc/BRIEF.md
# Receive End-of-Interrupt Command Handler

This block acts on the one-byte command that the host writes when it finishes servicing a receive interrupt on a serial channel. It owns a pair of receive DMA buffers used in ping-pong fashion. It places incoming bytes into the active buffer through a simple memory write port. Each buffer has a base descriptor and a byte counter.

A single accepted command can do several things at once. It can close the active buffer and switch DMA writes to the other buffer. It decides whether a pending exception character is dropped or written to memory. When the buffer is also closed, a kept exception character becomes the first byte of the new buffer. The same command can load either of two countdown timers from a value the host supplied earlier, and it records whether the host drained any FIFO data. A timer that counts down to zero raises a timer interrupt request, which stays set until the host acknowledges it.

Top module: `rx_eoi_ctrl`

## Requirements
- R1: After reset, act_buf is 0, done_flag is 2'b00, done_cnt is 0, nodata is 0, term_err is 0, tmr_irq is 0, mem_we is 0, and both timer values are 0.
- R2: A command is accepted only in a cycle where cmd_wr and isr_active are both 1 and cmd_data[2:0] is 3'b000. Any other write has no effect on any output or internal state.
- R3: A cycle with rx_we and no accepted command writes rx_data to address base[act_buf] + count[act_buf] in the next cycle (mem_we high for one cycle), then increments that count.
- R4: An accepted command with cmd_data[7] (terminate) set, while exc_pending and dma_mode are both 1, flips act_buf. It latches the closed buffer's count into done_cnt, sets done_flag[closed], and clears done_flag[new]. All of this is visible one cycle after the write.
- R5: On such a terminate with cmd_data[6] (discard) clear, exc_char is written at the new buffer's base, and the new buffer's count becomes 1. With discard set, the count becomes 0.
- R6: Exception handling happens only when dma_mode is 1. With discard set, exc_char is never written. An accepted non-terminate command with exc_pending and discard clear appends exc_char at the active buffer's current position.
- R7: An accepted terminate while exc_pending is 0 and dma_mode is 1 leaves act_buf unchanged and pulses term_err for exactly one cycle.
- R8: desc_wr loads desc_base into the active buffer's base descriptor. If it coincides with a terminate, the write lands in the buffer being closed and is kept for its next use.
- R9: With sync_mode at 1, cmd_data[5] loads timer 2 (8 bits) with tmr_val, and cmd_data[4] loads tmr_val into bits 15:8 of timer 1 while bits 7:0 keep their value. With sync_mode at 0, neither timer is loaded.
- R10: A non-zero timer decrements by one on each tick. The tick that takes it from 1 to 0 sets tmr_irq in the same clock. A timer at zero raises nothing until it is reloaded, and tmr_ack clears tmr_irq.
- R11: Each accepted command copies cmd_data[3] into nodata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| isr_active | input | 1 | Receive interrupt service is ending |
| exc_pending | input | 1 | An exception-character interrupt is pending |
| exc_char | input | 8 | The flagged exception character |
| dma_mode | input | 1 | Channel runs in DMA mode |
| sync_mode | input | 1 | Channel runs in a synchronous mode |
| tmr_val | input | 8 | Timer value supplied by the host |
| desc_wr | input | 1 | Descriptor write strobe for the active buffer |
| desc_base | input | 16 | New base address |
| rx_we | input | 1 | Received byte ready for DMA |
| rx_data | input | 8 | Received byte |
| tick | input | 1 | Timer prescaler tick |
| tmr_ack | input | 1 | Host acknowledge of timer interrupt |
| act_buf | output | 1 | Index of active buffer |
| done_cnt | output | 8 | Byte count of last closed buffer |
| done_flag | output | 2 | Per-buffer closed flag |
| nodata | output | 1 | Host reported no FIFO data read |
| term_err | output | 1 | One-cycle pulse on a rejected terminate |
| tmr_irq | output | 1 | Timer interrupt request |
| tmr1_val | output | 16 | Timer 1 value |
| tmr2_val | output | 8 | Timer 2 value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 8 | Memory write data |

## Verification
The assertions assume that every input is a known value on each clock edge from reset onward. They also assume that exc_pending and dma_mode do not change in the same cycle as a command write that they qualify. The stimulus drives each input on the falling edge, so that it is stable around the next rising edge. It never asserts rx_we in the same cycle as an accepted command, so each received byte has exactly one predicted memory write. The stimulus also holds exc_char steady across each command.

// File: rtl/rxeoi_pkg.sv
package rxeoi_pkg;
    localparam int BIT_TERM   = 7;
    localparam int BIT_DISC   = 6;
    localparam int BIT_LDT2   = 5;
    localparam int BIT_LDT1   = 4;
    localparam int BIT_NOXFER = 3;
    localparam int RSVD_W     = 3;

    typedef struct packed {
        logic valid;
        logic term;
        logic disc;
        logic ld_t2;
        logic ld_t1;
        logic no_xfer;
    } eoi_cmd_t;
endpackage

// File: rtl/rxeoi_decode.sv
module rxeoi_decode
    import rxeoi_pkg::*;
(
    input  logic       cmd_wr,
    input  logic       isr_active,
    input  logic [7:0] cmd_data,
    output eoi_cmd_t   cmd
);
    logic rsvd_clean;

    always_comb begin
        rsvd_clean    = (cmd_data[RSVD_W-1:0] == '0);
        cmd.valid     = cmd_wr && isr_active && rsvd_clean;
        cmd.term      = cmd_data[BIT_TERM];
        cmd.disc      = cmd_data[BIT_DISC];
        cmd.ld_t2     = cmd_data[BIT_LDT2];
        cmd.ld_t1     = cmd_data[BIT_LDT1];
        cmd.no_xfer   = cmd_data[BIT_NOXFER];
    end
endmodule

// File: rtl/rxeoi_timer.sv
module rxeoi_timer #(
    parameter int W       = 16,
    parameter bit HI_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [7:0]   load_val,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] load_word;

    generate
        if (HI_ONLY && W > 8) begin : g_hi
            assign load_word = {load_val, cnt_q[W-9:0]};
        end else begin : g_full
            assign load_word = W'(load_val);
        end
    endgenerate

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (load) begin
            cnt_d = load_word;
        end else if (tick && cnt_q != '0) begin
            cnt_d  = cnt_q - 1'b1;
            expire = (cnt_q == W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/rx_eoi_ctrl.sv
module rx_eoi_ctrl
    import rxeoi_pkg::*;
#(
    parameter int          AW    = 16,
    parameter int          CW    = 8,
    parameter int          T1W   = 16,
    parameter int          T2W   = 8,
    parameter logic [15:0] BASE0 = 16'h0100,
    parameter logic [15:0] BASE1 = 16'h0200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_wr,
    input  logic [7:0]     cmd_data,
    input  logic           isr_active,
    input  logic           exc_pending,
    input  logic [7:0]     exc_char,
    input  logic           dma_mode,
    input  logic           sync_mode,
    input  logic [7:0]     tmr_val,
    input  logic           desc_wr,
    input  logic [AW-1:0]  desc_base,
    input  logic           rx_we,
    input  logic [7:0]     rx_data,
    input  logic           tick,
    input  logic           tmr_ack,
    output logic           act_buf,
    output logic [CW-1:0]  done_cnt,
    output logic [1:0]     done_flag,
    output logic           nodata,
    output logic           term_err,
    output logic           tmr_irq,
    output logic [T1W-1:0] tmr1_val,
    output logic [T2W-1:0] tmr2_val,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_data
);
    localparam int NBUF = 2;

    typedef struct packed {
        logic                     act;
        logic [NBUF-1:0][AW-1:0]  base;
        logic [NBUF-1:0][CW-1:0]  cnt;
        logic [CW-1:0]            done_cnt;
        logic [NBUF-1:0]          done_flag;
        logic                     nodata;
        logic                     term_err;
        logic                     irq;
        logic                     mem_we;
        logic [AW-1:0]            mem_addr;
        logic [7:0]               mem_data;
    } state_t;

    state_t   s_d, s_q;
    eoi_cmd_t cmd;
    logic     t1_exp, t2_exp;
    logic     ld_t1, ld_t2;
    logic     nxt;

    rxeoi_decode u_dec (
        .cmd_wr     (cmd_wr),
        .isr_active (isr_active),
        .cmd_data   (cmd_data),
        .cmd        (cmd)
    );

    assign ld_t1 = cmd.valid && cmd.ld_t1 && sync_mode;
    assign ld_t2 = cmd.valid && cmd.ld_t2 && sync_mode;

    rxeoi_timer #(.W(T1W), .HI_ONLY(1'b1)) u_tmr1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_t1),
        .load_val (tmr_val),
        .tick     (tick),
        .count    (tmr1_val),
        .expire   (t1_exp)
    );

    rxeoi_timer #(.W(T2W), .HI_ONLY(1'b0)) u_tmr2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_t2),
        .load_val (tmr_val),
        .tick     (tick),
        .count    (tmr2_val),
        .expire   (t2_exp)
    );

    always_comb begin
        s_d          = s_q;
        nxt          = ~s_q.act;
        s_d.term_err = 1'b0;
        s_d.mem_we   = 1'b0;
        s_d.irq      = (s_q.irq && !tmr_ack) || t1_exp || t2_exp;

        if (desc_wr) s_d.base[s_q.act] = desc_base;

        if (cmd.valid) begin
            s_d.nodata = cmd.no_xfer;
            if (dma_mode) begin
                if (cmd.term && !exc_pending) begin
                    s_d.term_err = 1'b1;
                end else if (cmd.term) begin
                    s_d.act             = nxt;
                    s_d.done_cnt        = s_q.cnt[s_q.act];
                    s_d.done_flag[s_q.act] = 1'b1;
                    s_d.done_flag[nxt]  = 1'b0;
                    if (!cmd.disc) begin
                        s_d.mem_we   = 1'b1;
                        s_d.mem_addr = s_q.base[nxt];
                        s_d.mem_data = exc_char;
                        s_d.cnt[nxt] = CW'(1);
                    end else begin
                        s_d.cnt[nxt] = '0;
                    end
                end else if (exc_pending && !cmd.disc) begin
                    s_d.mem_we   = 1'b1;
                    s_d.mem_addr = s_q.base[s_q.act] + AW'(s_q.cnt[s_q.act]);
                    s_d.mem_data = exc_char;
                    s_d.cnt[s_q.act] = s_q.cnt[s_q.act] + 1'b1;
                end
            end
        end else if (rx_we) begin
            s_d.mem_we   = 1'b1;
            s_d.mem_addr = s_q.base[s_q.act] + AW'(s_q.cnt[s_q.act]);
            s_d.mem_data = rx_data;
            s_d.cnt[s_q.act] = s_q.cnt[s_q.act] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.base[0]   <= AW'(BASE0);
            s_q.base[1]   <= AW'(BASE1);
        end else begin
            s_q <= s_d;
        end
    end

    assign act_buf   = s_q.act;
    assign done_cnt  = s_q.done_cnt;
    assign done_flag = s_q.done_flag;
    assign nodata    = s_q.nodata;
    assign term_err  = s_q.term_err;
    assign tmr_irq   = s_q.irq;
    assign mem_we    = s_q.mem_we;
    assign mem_addr  = s_q.mem_addr;
    assign mem_data  = s_q.mem_data;
endmodule

// File: rtl/rx_eoi_ctrl_chk.sv
module rx_eoi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic [7:0] cmd_data,
    input logic       isr_active,
    input logic       exc_pending,
    input logic       dma_mode,
    input logic       rx_we,
    input logic       tick,
    input logic       act_buf,
    input logic [1:0] done_flag,
    input logic       nodata,
    input logic       term_err,
    input logic       tmr_irq,
    input logic       mem_we
);
    logic acc;
    assign acc = cmd_wr && isr_active && (cmd_data[2:0] == 3'b000);

    // R4
    term_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_data[7] && exc_pending && dma_mode |=> act_buf != $past(act_buf));

    // R7
    term_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cmd_data[7] && !exc_pending && dma_mode |=> term_err && $stable(act_buf));

    // R2
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (cmd_data[2:0] != 3'b000) |=> $stable(act_buf) && $stable(nodata) && !term_err);

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(act_buf));

    // R3
    mem_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(rx_we || cmd_wr));

    // R4
    act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_flag[act_buf]);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_irq) |-> $past(tick));
endmodule

bind rx_eoi_ctrl rx_eoi_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .cmd_data    (cmd_data),
    .isr_active  (isr_active),
    .exc_pending (exc_pending),
    .dma_mode    (dma_mode),
    .rx_we       (rx_we),
    .tick        (tick),
    .act_buf     (act_buf),
    .done_flag   (done_flag),
    .nodata      (nodata),
    .term_err    (term_err),
    .tmr_irq     (tmr_irq),
    .mem_we      (mem_we)
);

// File: tb/rx_eoi_ctrl_bench.sv
module rx_eoi_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        isr_active = 1'b1;
    logic        exc_pending = 1'b0;
    logic [7:0]  exc_char = '0;
    logic        dma_mode = 1'b1;
    logic        sync_mode = 1'b0;
    logic [7:0]  tmr_val = '0;
    logic        desc_wr = 1'b0;
    logic [15:0] desc_base = '0;
    logic        rx_we = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tick = 1'b0;
    logic        tmr_ack = 1'b0;
    logic        act_buf, nodata, term_err, tmr_irq, mem_we;
    logic [7:0]  done_cnt, tmr2_val, mem_data;
    logic [1:0]  done_flag;
    logic [15:0] tmr1_val, mem_addr;

    always #4 clk = ~clk;

    rx_eoi_ctrl u_rx_eoi_ctrl (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [23:0] exp_q[$];
    logic        m_act = 1'b0;
    logic [15:0] m_base [2] = '{16'h0100, 16'h0200};
    logic [7:0]  m_cnt  [2] = '{8'd0, 8'd0};
    logic [7:0]  m_done = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected mem write", {8'h0, mem_addr, mem_data}, 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_data} == e, "R3/R5/R6 mem write", {mem_addr, mem_data}, e);
            end
        end
    end

    task automatic rx_byte(input logic [7:0] d);
        @(negedge clk);
        rx_we = 1'b1; rx_data = d;
        exp_q.push_back({m_base[m_act] + 16'(m_cnt[m_act]), d});
        m_cnt[m_act] = m_cnt[m_act] + 1'b1;
        @(negedge clk);
        rx_we = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c, input bit with_desc, input logic [15:0] da);
        bit acc;
        acc = isr_active && (c[2:0] == 3'b000);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = c;
        desc_wr = with_desc; desc_base = da;
        if (with_desc) m_base[m_act] = da;
        if (acc && dma_mode && exc_pending) begin
            if (c[7]) begin
                m_done = m_cnt[m_act];
                m_act = !m_act;
                if (!c[6]) begin
                    exp_q.push_back({m_base[m_act], exc_char});
                    m_cnt[m_act] = 8'd1;
                end else begin
                    m_cnt[m_act] = 8'd0;
                end
            end else if (!c[6]) begin
                exp_q.push_back({m_base[m_act] + 16'(m_cnt[m_act]), exc_char});
                m_cnt[m_act] = m_cnt[m_act] + 1'b1;
            end
        end
        @(negedge clk);
        cmd_wr = 1'b0; desc_wr = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(act_buf == 0 && done_flag == 0 && done_cnt == 0 && nodata == 0, "R1 state", {act_buf, done_flag, done_cnt}, 0);
        chk(!term_err && !tmr_irq && !mem_we && tmr1_val == 0 && tmr2_val == 0, "R1 flags/timers", {tmr1_val, tmr2_val}, 0);

        // R3 received bytes
        rx_byte(8'h11); rx_byte(8'h22); rx_byte(8'h33);

        // R4 R5 terminate with carry-over
        exc_pending = 1'b1; exc_char = 8'hE5;
        send_cmd(8'h80, 1'b0, '0);
        chk(act_buf == 1, "R4 act flip", act_buf, 1);
        chk(done_cnt == 8'd3, "R4 done_cnt", done_cnt, 3);
        chk(done_flag == 2'b01, "R4 done_flag", done_flag, 2'b01);
        rx_byte(8'h44);

        // R7 terminate without pending exception
        exc_pending = 1'b0;
        send_cmd(8'h80, 1'b0, '0);
        chk(term_err == 1 && act_buf == 1, "R7 err pulse", {term_err, act_buf}, 2'b11);
        @(negedge clk);
        chk(term_err == 0, "R7 pulse one cycle", term_err, 0);

        // R8 R5 descriptor with terminate, discard
        exc_pending = 1'b1;
        send_cmd(8'hC0, 1'b1, 16'h0300);
        chk(act_buf == 0 && done_cnt == 8'd2, "R5 discard swap", {act_buf, done_cnt}, {1'b0, 8'd2});
        chk(done_flag == 2'b10, "R4 flags after second swap", done_flag, 2'b10);
        rx_byte(8'h55);
        send_cmd(8'hC0, 1'b0, '0);
        chk(done_cnt == m_done, "R8 done_cnt", done_cnt, m_done);
        rx_byte(8'h66);  // expected at 0x0300 (R8)

        // R6 append and discard without terminate
        send_cmd(8'h00, 1'b0, '0);
        send_cmd(8'h40, 1'b0, '0);
        rx_byte(8'h77);

        // R2 reserved bits and inactive service
        send_cmd(8'h89, 1'b0, '0);
        chk(act_buf == m_act && nodata == 0, "R2 reserved ignored", {act_buf, nodata}, {m_act, 1'b0});
        isr_active = 1'b0;
        send_cmd(8'h88, 1'b0, '0);
        chk(act_buf == m_act && nodata == 0, "R2 outside service ignored", {act_buf, nodata}, {m_act, 1'b0});
        isr_active = 1'b1;

        // R11 no-transfer record
        exc_pending = 1'b0;
        send_cmd(8'h08, 1'b0, '0);
        chk(nodata == 1, "R11 set", nodata, 1);
        send_cmd(8'h00, 1'b0, '0);
        chk(nodata == 0, "R11 clear", nodata, 0);

        // R6 non-DMA mode
        dma_mode = 1'b0; exc_pending = 1'b1;
        send_cmd(8'h80, 1'b0, '0);
        send_cmd(8'h00, 1'b0, '0);
        chk(act_buf == m_act && !term_err, "R6 non-DMA ignored", act_buf, m_act);
        dma_mode = 1'b1; exc_pending = 1'b0;

        // R9 R10 timers
        sync_mode = 1'b1; tmr_val = 8'd3;
        send_cmd(8'h20, 1'b0, '0);
        chk(tmr2_val == 8'd3, "R9 timer2 load", tmr2_val, 3);
        do_tick(); do_tick();
        chk(tmr2_val == 8'd1 && !tmr_irq, "R10 countdown", {tmr2_val, tmr_irq}, {8'd1, 1'b0});
        do_tick();
        chk(tmr_irq == 1 && tmr2_val == 0, "R10 irq on zero", tmr_irq, 1);
        @(negedge clk); tmr_ack = 1'b1;
        @(negedge clk); tmr_ack = 1'b0;
        chk(tmr_irq == 0, "R10 ack clears", tmr_irq, 0);
        do_tick(); do_tick();
        chk(tmr_irq == 0, "R10 zero timer silent", tmr_irq, 0);
        tmr_val = 8'd2;
        send_cmd(8'h10, 1'b0, '0);
        chk(tmr1_val == 16'h0200, "R9 timer1 high byte", tmr1_val, 16'h0200);
        do_tick();
        chk(tmr1_val == 16'h01FF, "R10 timer1 tick", tmr1_val, 16'h01FF);
        tmr_val = 8'd5;
        send_cmd(8'h10, 1'b0, '0);
        chk(tmr1_val == 16'h05FF, "R9 low byte kept", tmr1_val, 16'h05FF);
        sync_mode = 1'b0; tmr_val = 8'd9;
        send_cmd(8'h20, 1'b0, '0);
        chk(tmr2_val == 0, "R9 async no load", tmr2_val, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule